// File: doc/BRIEF.md
# Programmable Almost-Full/Almost-Empty Flag Controller

This block drives one status flag that warns of both ends of a 256-word buffer: it is high while the buffer holds few enough words to be nearly drained, and again while it holds enough to be nearly full. It holds two 7-bit margins, a low-end margin and a high-end margin. Both start at 32 after reset. It compares them, on every rising edge of the write clock, against the occupancy count that the surrounding buffer logic supplies.

Software or a host sets the margins through a short loading sequence on the write-clock side. It pulls the active-low load strobe and presents a value on the low seven data-input bits. The first edge with the strobe low copies that value into both margins. Each further consecutive edge with the strobe still low rewrites only the high-end margin. Loading is allowed only between reset and the first data word the buffer accepts. While a load is under way the block raises a write-inhibit output, so that the buffer does not store the load value as data.

Top module: `afae_flag_ctrl`

## Requirements
- R1: After reset, `afae_flag` is 1, `wr_block` is 0 while `prog_n` is 1, and both margins are 32.
- R2: With margins L (low) and H (high), the flag registered at a write-clock edge is 1 when the `fill_count` sampled at that edge is at most L or at least 256 - H, and 0 otherwise.
- R3: At the first rising edge with `prog_n` = 0 (after the strobe was high), `in_ready` = 1 and loading still permitted, `din_lo[6:0]` is stored as both L and H.
- R4: At each later rising edge with `prog_n` still 0 without a break, with `in_ready` = 1, only H is reloaded from `din_lo[6:0]`, and L keeps its value.
- R5: `wr_block` is 1 whenever `prog_n` = 0 while loading is permitted, whatever the value of `wr_en`. An edge with `wr_block` = 1 is not an accepted write.
- R6: The first accepted write (`wr_en` = 1, `in_ready` = 1, `wr_block` = 0 at an edge) ends the loading window. After that, `prog_n` has no effect on the margins or on `wr_block` until the next reset.
- R7: An edge with `prog_n` = 0 and `in_ready` = 0 loads nothing.
- R8: Margins of 127, the largest 7-bit value, are accepted. With L = H = 127 the flag is 0 only at occupancy 128.
- R9: The flag is a register that reflects the occupancy and margins present at the previous write-clock edge.
- R10: A new reset restores both margins to 32 and reopens the loading window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_n | input | 1 | Margin load strobe, active low |
| din_lo | input | 7 | Low data-input bits carrying the margin value |
| in_ready | input | 1 | Buffer not full; a load needs it high |
| wr_en | input | 1 | Combined write request from the buffer's write enables |
| fill_count | input | 9 | Current number of stored words (0 to 256) |
| afae_flag | output | 1 | Combined almost-empty / almost-full flag |
| wr_block | output | 1 | Inhibits buffer writes during a margin load |

## Verification
A wrong margin register stays hidden until the occupancy reaches one of its edges. The bench therefore walks the count across the edge values on both sides of each threshold, one edge after every load. A mis-stored margin then shows as a wrong flag value one write-clock cycle after the count is presented. A loading window that stays open too long, or that closes too early, shows at `wr_block` in the same cycle as the strobe, and at the flag edges as a changed margin. A faulty load sequence, where the second edge also rewrites the low margin, shows at the low boundary only. For that reason the low and high boundaries are checked separately after each multi-edge load.

// File: rtl/afae_pkg.sv
package afae_pkg;

    // Position in a margin load burst.
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_AGAIN = 1'b1
    } load_seq_e;

endpackage

// File: rtl/afae_load_seq.sv
module afae_load_seq
    import afae_pkg::*;
#(
    parameter int OFS_W       = 7,
    parameter int DEFAULT_OFS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_n,
    input  logic [OFS_W-1:0] din,
    input  logic             in_ready,
    input  logic             wr_en,
    output logic [OFS_W-1:0] low_ofs,
    output logic [OFS_W-1:0] high_ofs,
    output logic             wr_block
);

    localparam logic [OFS_W-1:0] RST_OFS = OFS_W'(DEFAULT_OFS);

    typedef struct packed {
        logic             window;
        load_seq_e        seq;
        logic [OFS_W-1:0] lo;
        logic [OFS_W-1:0] hi;
    } load_st_t;

    load_st_t st_d, st_q;
    logic     blk;
    logic     accept;
    logic     load;

    always_comb begin
        st_d   = st_q;
        blk    = st_q.window & ~prog_n;
        accept = wr_en & in_ready & ~blk;
        load   = st_q.window & ~prog_n & in_ready;

        if (accept) begin
            st_d.window = 1'b0;
        end

        if (load) begin
            if (st_q.seq == SEQ_AGAIN) begin
                st_d.hi = din;
            end else begin
                st_d.lo = din;
                st_d.hi = din;
            end
            st_d.seq = SEQ_AGAIN;
        end else if (prog_n) begin
            st_d.seq = SEQ_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{window: 1'b1, seq: SEQ_IDLE, lo: RST_OFS, hi: RST_OFS};
        end else begin
            st_q <= st_d;
        end
    end

    assign low_ofs  = st_q.lo;
    assign high_ofs = st_q.hi;
    assign wr_block = blk;

endmodule

// File: rtl/afae_thresh_cmp.sv
module afae_thresh_cmp #(
    parameter int DEPTH = 256,
    parameter int OFS_W = 7,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [OFS_W-1:0] low_ofs,
    input  logic [OFS_W-1:0] high_ofs,
    output logic             flag
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        logic flag;
    } cmp_st_t;

    cmp_st_t    st_d, st_q;
    logic       near_empty;
    logic       near_full;
    logic [CNT_W-1:0] full_edge;

    always_comb begin
        full_edge  = DEPTH_C - CNT_W'(high_ofs);
        near_empty = count <= CNT_W'(low_ofs);
        near_full  = count >= full_edge;
        st_d.flag  = near_empty | near_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/afae_flag_ctrl.sv
module afae_flag_ctrl #(
    parameter int DEPTH       = 256,
    parameter int OFS_W       = 7,
    parameter int DEFAULT_OFS = 32,
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             prog_n,
    input  logic [OFS_W-1:0] din_lo,
    input  logic             in_ready,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] fill_count,
    output logic             afae_flag,
    output logic             wr_block
);

    logic [OFS_W-1:0] low_ofs;
    logic [OFS_W-1:0] high_ofs;

    afae_load_seq #(
        .OFS_W       (OFS_W),
        .DEFAULT_OFS (DEFAULT_OFS)
    ) i_load (
        .clk      (wclk),
        .rst_n    (rst_n),
        .prog_n   (prog_n),
        .din      (din_lo),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .low_ofs  (low_ofs),
        .high_ofs (high_ofs),
        .wr_block (wr_block)
    );

    afae_thresh_cmp #(
        .DEPTH (DEPTH),
        .OFS_W (OFS_W),
        .CNT_W (CNT_W)
    ) i_cmp (
        .clk      (wclk),
        .rst_n    (rst_n),
        .count    (fill_count),
        .low_ofs  (low_ofs),
        .high_ofs (high_ofs),
        .flag     (afae_flag)
    );

endmodule

// File: rtl/afae_flag_chk.sv
module afae_flag_chk #(
    parameter int DEPTH = 256,
    parameter int OFS_W = 7,
    parameter int CNT_W = 9
) (
    input logic             wclk,
    input logic             rst_n,
    input logic             prog_n,
    input logic             in_ready,
    input logic             wr_en,
    input logic [CNT_W-1:0] fill_count,
    input logic             afae_flag,
    input logic             wr_block
);

    logic written_q;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            written_q <= 1'b0;
        end else if (wr_en && in_ready && !wr_block) begin
            written_q <= 1'b1;
        end
    end

    // R5
    block_needs_strobe_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_block |-> !prog_n);

    // R6
    closed_after_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        written_q |-> !wr_block);

    // R2
    empty_flags_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (fill_count == '0) |=> afae_flag);

    // R2
    full_flags_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (fill_count == CNT_W'(DEPTH)) |=> afae_flag);

    // R9
    flag_held_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        ($stable(fill_count) && prog_n && $past(prog_n)) |=> $stable(afae_flag));

endmodule

bind afae_flag_ctrl afae_flag_chk #(
    .DEPTH (DEPTH),
    .OFS_W (OFS_W),
    .CNT_W (CNT_W)
) i_afae_chk (
    .wclk       (wclk),
    .rst_n      (rst_n),
    .prog_n     (prog_n),
    .in_ready   (in_ready),
    .wr_en      (wr_en),
    .fill_count (fill_count),
    .afae_flag  (afae_flag),
    .wr_block   (wr_block)
);

// File: tb/test_afae_flag_ctrl.sv
module test_afae_flag_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;
    localparam int OFS_W      = 7;
    localparam int CNT_W      = 9;

    logic             wclk = 1'b0;
    logic             rst_n = 1'b0;
    logic             prog_n = 1'b1;
    logic [OFS_W-1:0] din_lo = '0;
    logic             in_ready = 1'b1;
    logic             wr_en = 1'b0;
    logic [CNT_W-1:0] fill_count = '0;
    logic             afae_flag;
    logic             wr_block;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    stamp;
        logic  exp;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    afae_flag_ctrl i_afae_flag_ctrl (
        .wclk       (wclk),
        .rst_n      (rst_n),
        .prog_n     (prog_n),
        .din_lo     (din_lo),
        .in_ready   (in_ready),
        .wr_en      (wr_en),
        .fill_count (fill_count),
        .afae_flag  (afae_flag),
        .wr_block   (wr_block)
    );

    always #(CLK_PERIOD / 2) wclk = ~wclk;

    always @(posedge wclk) cyc <= cyc + 1;

    // Monitor: compare each expectation once a rising edge has passed.
    always @(negedge wclk) begin
        while (sb_q.size() > 0 && sb_q[0].stamp < cyc) begin
            exp_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (afae_flag !== it.exp) begin
                failures++;
                $display("FAIL %s afae_flag actual=%b expected=%b", it.tag, afae_flag, it.exp);
            end
        end
    end

    task automatic check_now(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic model_flag(input int cnt, input int lo, input int hi);
        return (cnt <= lo) || (cnt >= DEPTH - hi);
    endfunction

    // Driver: present an occupancy, queue the expected flag.
    task automatic probe(input int cnt, input int lo, input int hi, input string tag);
        exp_item_t it;
        @(negedge wclk);
        fill_count = CNT_W'(cnt);
        it.stamp = cyc;
        it.exp   = model_flag(cnt, lo, hi);
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        repeat (2) @(negedge wclk);
    endtask

    // Load burst: one value per consecutive edge with the strobe low.
    task automatic load_burst(input int vals[$]);
        foreach (vals[i]) begin
            @(negedge wclk);
            prog_n = 1'b0;
            din_lo = OFS_W'(vals[i]);
        end
        @(negedge wclk);
        prog_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge wclk);
        rst_n = 1'b0;
        prog_n = 1'b1;
        wr_en = 1'b0;
        fill_count = '0;
        repeat (4) @(negedge wclk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge wclk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge wclk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check_now(afae_flag, 1'b1, "R1 flag after reset");
        check_now(wr_block, 1'b0, "R1 wr_block after reset");

        // R1 R2 default margins 32/32
        probe(32, 32, 32, "R2 default low edge");
        probe(33, 32, 32, "R2 default above low");
        probe(128, 32, 32, "R2 default middle");
        probe(223, 32, 32, "R2 default below high");
        probe(224, 32, 32, "R2 default high edge");
        probe(256, 32, 32, "R2 default full");
        probe(0, 32, 32, "R2 default empty");
        drain();

        // R5 strobe with write request: blocked
        @(negedge wclk);
        prog_n = 1'b0;
        din_lo = 7'd10;
        wr_en = 1'b1;
        #1;
        check_now(wr_block, 1'b1, "R5 wr_block with wr_en high");
        @(negedge wclk);
        prog_n = 1'b1;
        wr_en = 1'b0;
        #1;
        check_now(wr_block, 1'b0, "R5 wr_block released");

        // R3 single edge loads both margins (10/10)
        probe(10, 10, 10, "R3 equal low edge");
        probe(11, 10, 10, "R3 equal above low");
        probe(245, 10, 10, "R3 equal below high");
        probe(246, 10, 10, "R3 equal high edge");
        drain();

        // R4 two edges: low 20, high 40
        load_burst('{20, 40});
        probe(20, 20, 40, "R4 split low edge");
        probe(21, 20, 40, "R4 split above low");
        probe(215, 20, 40, "R4 split below high");
        probe(216, 20, 40, "R4 split high edge");
        drain();

        // R4 three edges: low 5, high 60
        load_burst('{5, 50, 60});
        probe(5, 5, 60, "R4 long low edge");
        probe(6, 5, 60, "R4 long above low");
        probe(195, 5, 60, "R4 long below high");
        probe(196, 5, 60, "R4 long high edge");
        drain();

        // R7 strobe without in_ready: nothing loaded
        @(negedge wclk);
        in_ready = 1'b0;
        prog_n = 1'b0;
        din_lo = 7'd100;
        @(negedge wclk);
        prog_n = 1'b1;
        in_ready = 1'b1;
        probe(6, 5, 60, "R7 low kept");
        probe(195, 5, 60, "R7 high kept");
        drain();

        // R8 maximum margins
        load_burst('{127});
        probe(127, 127, 127, "R8 max low edge");
        probe(128, 127, 127, "R8 max middle");
        probe(129, 127, 127, "R8 max high edge");
        drain();

        // R6 accepted write closes the window
        @(negedge wclk);
        wr_en = 1'b1;
        @(negedge wclk);
        wr_en = 1'b0;
        prog_n = 1'b0;
        din_lo = 7'd0;
        #1;
        check_now(wr_block, 1'b0, "R6 wr_block after first write");
        @(negedge wclk);
        prog_n = 1'b1;
        probe(128, 127, 127, "R6 margins unchanged");
        probe(127, 127, 127, "R6 low margin unchanged");
        drain();

        // R10 reset restores defaults and reopens loading
        do_reset();
        #1;
        check_now(afae_flag, 1'b1, "R10 flag after reset");
        probe(33, 32, 32, "R10 default above low");
        probe(32, 32, 32, "R10 default low edge");
        probe(224, 32, 32, "R10 default high edge");
        drain();
        @(negedge wclk);
        prog_n = 1'b0;
        #1;
        check_now(wr_block, 1'b1, "R10 window reopened");
        @(negedge wclk);
        prog_n = 1'b1;
        // R9 registered: change count, flag holds until the next edge
        @(negedge wclk);
        fill_count = 9'd100;
        @(negedge wclk);
        fill_count = 9'd0;
        #1;
        check_now(afae_flag, 1'b0, "R9 flag before edge");
        @(negedge wclk);
        check_now(afae_flag, 1'b1, "R9 flag after edge");
        drain();

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule